// File: doc/BRIEF.md
# Special Cycle Delayed-Transaction Sequencer

This block carries one configuration write, already flagged by an upstream address decoder for conversion into a broadcast special cycle, across a bridge as a delayed transaction. On the initiating side it behaves as a target. It latches the address, command and first data word of the flagged attempt and answers that attempt with a retry. On the far side it behaves as a master. It presents the latched address and data with the command replaced by the special cycle code, and holds the request until the far side takes it.

No device claims a special cycle, so the far side always ends it with a master abort. The block treats that abort as successful completion and does not pass it back. Until the abort arrives, every attempt on the initiating side is retried. Once it has arrived, the first attempt that repeats the held transaction exactly receives TRDY. If that attempt asks for more than one data phase, it is also disconnected, which limits the transfer to a single data phase. The entry is then freed. Special cycles that reach the initiating side are never answered and never captured.

Top module: `spcyc_seq`

## Requirements
- R1: Synchronous reset, active high, leaves the block empty: `req_valid`, `att_retry`, `att_trdy` and `att_disc` are all low.
- R2: When the block is empty, an attempt with `att_conv` high and command 4'b1011 (configuration write) is answered with `att_retry` in the same cycle, and its address, command and data are captured.
- R3: After a capture, `req_valid` is high from the next cycle until a cycle in which `req_ack` is high. During that time `req_cmd` is 4'b0001 (special cycle), and `req_addr` and `req_data` equal the captured address and data.
- R4: While an entry is held and the far-side abort has not yet been seen, every attempt on the initiating side whose command is not 4'b0001 receives `att_retry` and no `att_trdy`.
- R5: Once the far side has accepted the request, the block waits for `req_mabort`. The abort is never passed back: the matching attempt that follows it receives `att_trdy`, not a retry. A `req_mabort` pulse before acceptance is ignored.
- R6: After the abort, an attempt matching the held entry receives `att_trdy`, and the entry is cleared in that cycle. A new flagged write is then captured again as in R2.
- R7: An attempt that receives `att_trdy` while `att_multi` is high also receives `att_disc` in the same cycle. `att_disc` is never high without `att_trdy`.
- R8: An attempt with command 4'b0001 receives no `att_retry` and no `att_trdy`, changes no state and is never captured, whatever state the block is in.
- R9: An attempt matches only when its address, command and data all equal the captured values. After the abort, a non-matching attempt (command not 4'b0001) is retried and the entry stays held.
- R10: When the block is empty, an attempt whose `att_conv` is low, or whose command is not 4'b1011, gets no response and is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| att_valid | input | 1 | An attempt is present on the initiating side this cycle |
| att_addr | input | AW | Attempt address |
| att_cmd | input | 4 | Attempt bus command |
| att_data | input | DW | Attempt first data word |
| att_conv | input | 1 | Decoder flag: convert this write into a special cycle |
| att_multi | input | 1 | Attempt requests more than one data phase |
| att_retry | output | 1 | Retry the attempt |
| att_trdy | output | 1 | Complete the attempt's first data phase |
| att_disc | output | 1 | Disconnect after the first data phase |
| req_valid | output | 1 | Far-side request present |
| req_addr | output | AW | Far-side address (captured value) |
| req_cmd | output | 4 | Far-side command (special cycle) |
| req_data | output | DW | Far-side data, the special cycle message |
| req_ack | input | 1 | Far side took the request |
| req_mabort | input | 1 | Far side ended the cycle with a master abort |

## Verification
The bench builds the block with 16-bit address and 16-bit data. This keeps the values readable while leaving room for attempts that differ from the held entry in a single field: address only, data only, or command only. A behavioural model with its own state tracking is compared with every response and far-side output on each clock. The stimulus covers acknowledge delays, aborts that arrive too early and are ignored, special-cycle attempts in each state, and multi-phase and single-phase completions followed by a fresh capture.

// File: rtl/spcyc_pkg.sv
package spcyc_pkg;

    localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;
    localparam logic [3:0] CMD_SPECIAL   = 4'b0001;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CAPTURED = 2'd1,
        ST_WAIT_AB  = 2'd2,
        ST_CMPL     = 2'd3
    } spcyc_state_e;

    function automatic logic is_special(input logic [3:0] cmd);
        return cmd == CMD_SPECIAL;
    endfunction

    function automatic logic is_cfg_write(input logic [3:0] cmd);
        return cmd == CMD_CFG_WRITE;
    endfunction

endpackage

// File: rtl/spcyc_hold.sv
module spcyc_hold #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] in_addr,
    input  logic [3:0]    in_cmd,
    input  logic [DW-1:0] in_data,
    output logic [AW-1:0] q_addr,
    output logic [3:0]    q_cmd,
    output logic [DW-1:0] q_data
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [3:0]    cmd;
        logic [DW-1:0] data;
    } entry_t;

    entry_t ent_q;

    always_ff @(posedge clk) begin
        if (rst)
            ent_q <= '0;
        else if (load)
            ent_q <= '{addr: in_addr, cmd: in_cmd, data: in_data};
    end

    assign q_addr = ent_q.addr;
    assign q_cmd  = ent_q.cmd;
    assign q_data = ent_q.data;
endmodule

// File: rtl/spcyc_match.sv
module spcyc_match #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] a_addr,
    input  logic [3:0]    a_cmd,
    input  logic [DW-1:0] a_data,
    input  logic [AW-1:0] h_addr,
    input  logic [3:0]    h_cmd,
    input  logic [DW-1:0] h_data,
    output logic          hit
);
    logic [2:0] fld_eq;

    assign fld_eq[0] = (a_addr == h_addr);
    assign fld_eq[1] = (a_cmd  == h_cmd);
    assign fld_eq[2] = (a_data == h_data);
    assign hit = &fld_eq;
endmodule

// File: rtl/spcyc_ctrl.sv
module spcyc_ctrl
    import spcyc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         att_live,
    input  logic         att_new,
    input  logic         att_multi,
    input  logic         hit,
    input  logic         req_ack,
    input  logic         req_mabort,
    output spcyc_state_e state,
    output logic         load,
    output logic         retry,
    output logic         trdy,
    output logic         disc,
    output logic         req
);
    spcyc_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt   = state;
        load  = 1'b0;
        retry = 1'b0;
        trdy  = 1'b0;
        disc  = 1'b0;
        req   = (state == ST_CAPTURED);
        unique case (state)
            ST_IDLE: begin
                if (att_live && att_new) begin
                    load  = 1'b1;
                    retry = 1'b1;
                    nxt   = ST_CAPTURED;
                end
            end
            ST_CAPTURED: if (req_ack)    nxt = ST_WAIT_AB;
            ST_WAIT_AB:  if (req_mabort) nxt = ST_CMPL;
            ST_CMPL: ;
            default: nxt = ST_IDLE;
        endcase
        if (state != ST_IDLE && att_live) begin
            if (state == ST_CMPL && hit) begin
                trdy = 1'b1;
                disc = att_multi;
                nxt  = ST_IDLE;
            end else begin
                retry = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spcyc_seq.sv
module spcyc_seq
    import spcyc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          att_valid,
    input  logic [AW-1:0] att_addr,
    input  logic [3:0]    att_cmd,
    input  logic [DW-1:0] att_data,
    input  logic          att_conv,
    input  logic          att_multi,
    output logic          att_retry,
    output logic          att_trdy,
    output logic          att_disc,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic [3:0]    req_cmd,
    output logic [DW-1:0] req_data,
    input  logic          req_ack,
    input  logic          req_mabort
);
    spcyc_state_e  state;
    logic          att_live, att_new, load, hit;
    logic [AW-1:0] h_addr;
    logic [3:0]    h_cmd;
    logic [DW-1:0] h_data;

    // incoming special cycles are invisible to this block
    assign att_live = att_valid && !is_special(att_cmd);
    assign att_new  = att_conv && is_cfg_write(att_cmd);

    spcyc_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk(clk), .rst(rst), .load(load),
        .in_addr(att_addr), .in_cmd(att_cmd), .in_data(att_data),
        .q_addr(h_addr), .q_cmd(h_cmd), .q_data(h_data)
    );

    spcyc_match #(.AW(AW), .DW(DW)) u_match (
        .a_addr(att_addr), .a_cmd(att_cmd), .a_data(att_data),
        .h_addr(h_addr), .h_cmd(h_cmd), .h_data(h_data),
        .hit(hit)
    );

    spcyc_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .att_live(att_live), .att_new(att_new), .att_multi(att_multi),
        .hit(hit), .req_ack(req_ack), .req_mabort(req_mabort),
        .state(state), .load(load),
        .retry(att_retry), .trdy(att_trdy), .disc(att_disc),
        .req(req_valid)
    );

    // command substitution on the far side; address and data unchanged
    assign req_addr = h_addr;
    assign req_data = h_data;
    assign req_cmd  = req_valid ? CMD_SPECIAL : 4'b0000;
endmodule

// File: rtl/spcyc_seq_chk.sv
module spcyc_seq_chk
    import spcyc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          att_valid,
    input logic [3:0]    att_cmd,
    input logic          att_retry,
    input logic          att_trdy,
    input logic          att_disc,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_data,
    input logic          req_ack,
    input spcyc_state_e  state
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_data));

    // R2
    req_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(att_retry));

    // R7
    disc_with_trdy_chk: assert property (@(posedge clk) disable iff (rst)
        att_disc |-> att_trdy);

    // R8
    special_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        att_valid && att_cmd == CMD_SPECIAL |-> !att_retry && !att_trdy);

    // R4
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(att_retry && att_trdy));

    // R6
    clear_after_trdy_chk: assert property (@(posedge clk) disable iff (rst)
        att_trdy |=> state == ST_IDLE && !req_valid);
endmodule

bind spcyc_seq spcyc_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .att_valid(att_valid), .att_cmd(att_cmd),
    .att_retry(att_retry), .att_trdy(att_trdy), .att_disc(att_disc),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_ack(req_ack), .state(state)
);

// File: tb/spcyc_seq_test.sv
module spcyc_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          att_valid = 1'b0;
    logic [AW-1:0] att_addr = '0;
    logic [3:0]    att_cmd = '0;
    logic [DW-1:0] att_data = '0;
    logic          att_conv = 1'b0;
    logic          att_multi = 1'b0;
    logic          att_retry, att_trdy, att_disc, req_valid;
    logic [AW-1:0] req_addr;
    logic [3:0]    req_cmd;
    logic [DW-1:0] req_data;
    logic          req_ack = 1'b0;
    logic          req_mabort = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: 0 empty, 1 requesting, 2 awaiting abort, 3 abort seen
    int            m_st = 0;
    logic [AW-1:0] m_addr;
    logic [3:0]    m_cmd;
    logic [DW-1:0] m_data;

    spcyc_seq #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst),
        .att_valid(att_valid), .att_addr(att_addr), .att_cmd(att_cmd),
        .att_data(att_data), .att_conv(att_conv), .att_multi(att_multi),
        .att_retry(att_retry), .att_trdy(att_trdy), .att_disc(att_disc),
        .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_data(req_data), .req_ack(req_ack), .req_mabort(req_mabort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit e_retry, e_trdy, e_disc, e_req, live, same;
            int nst;
            e_retry = 0; e_trdy = 0; e_disc = 0;
            nst = m_st;
            e_req = (m_st == 1);
            live = att_valid && (att_cmd != 4'b0001);
            same = (att_addr == m_addr) && (att_cmd == m_cmd) && (att_data == m_data);
            if (rst) begin
                nst = 0;
            end else begin
                if (m_st == 0) begin
                    if (live && att_conv && att_cmd == 4'b1011) begin
                        e_retry = 1;
                        m_addr = att_addr; m_cmd = att_cmd; m_data = att_data;
                        nst = 1;
                    end
                end else begin
                    if (m_st == 1 && req_ack) nst = 2;
                    if (m_st == 2 && req_mabort) nst = 3;
                    if (live) begin
                        if (m_st == 3 && same) begin
                            e_trdy = 1; e_disc = att_multi; nst = 0;
                        end else e_retry = 1;
                    end
                end
            end
            chk(rst ? "R1" : "R2_R4_R9", "retry", 32'(att_retry), 32'(e_retry));
            chk(rst ? "R1" : "R5_R6", "trdy", 32'(att_trdy), 32'(e_trdy));
            chk(rst ? "R1" : "R7", "disc", 32'(att_disc), 32'(e_disc));
            chk(rst ? "R1" : "R3", "req_valid", 32'(req_valid), 32'(e_req));
            if (e_req) begin
                chk("R3", "req_cmd", 32'(req_cmd), 32'h1);
                chk("R3", "req_addr", 32'(req_addr), 32'(m_addr));
                chk("R3", "req_data", 32'(req_data), 32'(m_data));
            end
            if (att_valid && att_cmd == 4'b0001)
                chk("R8", "special_resp", 32'({att_retry, att_trdy}), 32'h0);
            m_st = nst;
        end
    end

    task automatic step();
        @(posedge clk); #1;
        att_valid = 0; att_conv = 0; att_multi = 0;
        req_ack = 0; req_mabort = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic attempt(input logic [AW-1:0] a, input logic [3:0] c,
                           input logic [DW-1:0] d, input bit conv, input bit multi);
        att_valid = 1; att_addr = a; att_cmd = c; att_data = d;
        att_conv = conv; att_multi = multi;
        step();
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0; #0;
        idle(1);
        // R10: not flagged, and flagged but not a configuration write
        attempt(16'h1234, 4'b1011, 16'h00AA, 0, 0);
        attempt(16'h1234, 4'b1010, 16'h00AA, 1, 0);
        // R8: special cycle arriving while empty
        attempt(16'h8001, 4'b0001, 16'h0055, 1, 0);
        // R2: capture
        attempt(16'hC001, 4'b1011, 16'h5A5A, 1, 1);
        idle(2);
        // R4: attempts while requesting
        attempt(16'hC001, 4'b1011, 16'h5A5A, 1, 1);
        attempt(16'hC003, 4'b1011, 16'h5A5A, 1, 0);
        // R8 while held
        attempt(16'hC001, 4'b0001, 16'h5A5A, 0, 0);
        // R5: early abort ignored
        req_mabort = 1; step();
        idle(1);
        req_ack = 1; step();
        attempt(16'hC001, 4'b1011, 16'h5A5A, 1, 1);
        idle(2);
        req_mabort = 1; step();
        // R9: single-field mismatches retried
        attempt(16'hC001, 4'b1011, 16'h5A5B, 1, 1);
        attempt(16'hC401, 4'b1011, 16'h5A5A, 1, 1);
        attempt(16'hC001, 4'b1010, 16'h5A5A, 1, 1);
        attempt(16'hC001, 4'b0001, 16'h5A5A, 1, 1);
        // R6/R7: matching multi-phase attempt completes with disconnect
        attempt(16'hC001, 4'b1011, 16'h5A5A, 1, 1);
        attempt(16'hC001, 4'b1011, 16'h5A5A, 0, 0);
        idle(1);
        // second transaction, ack in the same cycle request appears
        attempt(16'h0F0D, 4'b1011, 16'hFFFF, 1, 0);
        req_ack = 1; step();
        req_mabort = 1;
        att_valid = 1; att_addr = 16'h0F0D; att_cmd = 4'b1011; att_data = 16'hFFFF;
        step();
        attempt(16'h0F0D, 4'b1011, 16'hFFFF, 0, 0);
        // R6: cleared, fresh capture
        attempt(16'h0002, 4'b1011, 16'h0000, 1, 0);
        req_ack = 1; step();
        req_mabort = 1; step();
        attempt(16'h0002, 4'b1011, 16'h0000, 1, 1);
        // R1: reset in the middle of a held entry
        attempt(16'h7777, 4'b1011, 16'h1111, 1, 0);
        rst = 1; step(); rst = 0;
        idle(2);
        attempt(16'h7777, 4'b1011, 16'h1111, 0, 0);
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule